// File: doc/BRIEF.md
# Record Slot Map Manager

This block tracks which fixed-size storage slots hold error records. It keeps one 64-bit record identifier per slot and a count of occupied slots. The lowest `FIRST_IDX` slot indices belong to a storage header and never carry records. Slot index 0 therefore never names a record, and a response uses it to mean "no slot". Copying record payloads is left to the surrounding logic. The block only decides which slot a record lives in and reports a status.

A requester issues one operation at a time over a valid/ready request channel. The operations are: look up an identifier, find a free slot, write (allocate or overwrite), clear, step a stored-identifier iterator, and rewind that iterator. `req_ready` is high only while the block is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high.

The block examines one map entry per clock and then presents a result on a valid/ready response channel. The response holds its value until the requester raises `rsp_ready`, and no new request is accepted until that handshake has taken place. Back-pressure on the response channel therefore stalls the request channel. An identifier of 0 marks a free slot and an all-ones identifier marks "end", so neither value can be stored.

Top module: `slot_map_mgr`

## Requirements
- R1: After reset, `rec_count` is 0, `req_ready` is 1, `rsp_valid` is 0, every record slot is free and the iterator stands at `FIRST_IDX`.
- R2: A request is taken only while `req_ready` is high. `req_ready` stays low from the accepting edge until the edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_valid` is high and `rsp_ready` is low, `rsp_status`, `rsp_index` and `rsp_id` hold steady.
- R3: `req_op` is encoded as 0 lookup, 1 find-free, 2 write, 3 clear, 4 next, 5 rewind. `rsp_status` is encoded as 0x00 ok, 0x01 no space, 0x03 failed, 0x05 not found. Any status other than ok comes with `rsp_index` 0, and every operation other than next and rewind echoes the request identifier on `rsp_id`. Op codes 6 and 7 return 0x03 and change neither the map nor the count.
- R4: A write of a valid identifier that is not stored takes the lowest free slot in the range `FIRST_IDX`..`NUM_SLOTS-1`. It returns ok with that index and increments `rec_count`.
- R5: A write of an identifier that is already stored returns ok with that same slot and leaves `rec_count` unchanged.
- R6: A write of a new identifier when every record slot is occupied returns 0x01. A write of identifier 0 or all-ones returns 0x03 and stores nothing.
- R7: A lookup returns ok with the slot that holds the identifier, or 0x05 if no slot holds it. A lookup for identifier 0 always returns 0x05.
- R8: Clearing identifier 0 or all-ones returns 0x03, and clearing an absent identifier returns 0x05. Clearing a stored identifier returns ok with its slot, frees the slot for later writes and decrements `rec_count`.
- R9: Find-free returns ok with the lowest free record slot, or 0x01 when none is free. It changes nothing.
- R10: Next returns ok with the first occupied slot at or after the saved position, puts that slot's identifier on `rsp_id`, and saves slot+1 as the new position. When no such slot exists it returns index 0 with `rsp_id` all-ones and moves the saved position back to `FIRST_IDX`.
- R11: Rewind behaves like next but starts from `FIRST_IDX`. When `rec_count` is 0, next and rewind both return all-ones at once and reset the position.
- R12: Latency is the number of rising edges after the accepting edge that pass before `rsp_valid` is high. An immediate answer (lookup of identifier 0, invalid-identifier write or clear, unknown op) has latency 0. A lookup hit in slot s, with all lower record slots occupied, has latency s-`FIRST_IDX`+1. A lookup miss with c records stored in the lowest c record slots has latency c+1, because the scan stops once it has passed c occupied entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 3 | Operation code (R3) |
| req_id | input | ID_W | Record identifier for the operation |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_status | output | 8 | Completion status code |
| rsp_index | output | IDX_W | Slot index, 0 meaning none |
| rsp_id | output | ID_W | Echoed identifier, or iterator result |
| rec_count | output | CNT_W | Number of occupied record slots |

## Verification
The main function is driven through a small map (eight slots, two of them reserved for the header). First comes a directed sequence. Contiguous fills expose the early-stop lookup latency, which differs from the latency of a full scan. Back-to-back writes of the same identifier separate overwrite from allocation. Filling the map to capacity brings out the no-space paths, and clearing a middle slot shows that freed slots are reused lowest-first. A walk of the iterator past its end checks the all-ones answer and the wrap back to the start. After that, a long pseudo-random mix draws identifiers from a pool larger than the map, including 0 and all-ones. This mix moves through full, empty and fragmented states, so stale iterator positions, holes below the iterator and unknown op codes all occur against the expected values the bench keeps.

// File: rtl/slot_map_pkg.sv
package slot_map_pkg;

  typedef enum logic [2:0] {
    OP_LOOKUP    = 3'd0,
    OP_FIND_FREE = 3'd1,
    OP_WRITE     = 3'd2,
    OP_CLEAR     = 3'd3,
    OP_NEXT      = 3'd4,
    OP_REWIND    = 3'd5
  } map_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MATCH,
    ST_FREE,
    ST_ITER,
    ST_RESP
  } ctrl_state_e;

  localparam logic [7:0] STAT_OK       = 8'h00;
  localparam logic [7:0] STAT_NO_SPACE = 8'h01;
  localparam logic [7:0] STAT_FAILED   = 8'h03;
  localparam logic [7:0] STAT_NOTFOUND = 8'h05;

endpackage

// File: rtl/slot_map_store.sv
module slot_map_store #(
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 2,
  parameter int ID_W      = 64,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ID_W-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ID_W-1:0]  wr_data
);

  logic [ID_W-1:0] ent [NUM_SLOTS];

  // Header slots hold no flops; a write aimed at them or past the end
  // matches no record slot and is dropped.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g < FIRST_IDX) begin : g_hdr
      assign ent[g] = '0;
    end else begin : g_rec
      logic [ID_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          val_q <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          val_q <= wr_data;
        end
      end
      assign ent[g] = val_q;
    end
  end

  // Out-of-range read indices return a free-looking entry.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_data = ent[i];
      end
    end
  end

endmodule

// File: rtl/slot_map_count.sv
module slot_map_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/slot_map_iter.sv
module slot_map_iter #(
  parameter int FIRST_IDX = 2,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  output logic [IDX_W-1:0] pos
);

  localparam logic [IDX_W-1:0] START = IDX_W'(FIRST_IDX);

  logic [IDX_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= START;
    end else if (restart) begin
      pos_q <= START;
    end else if (load) begin
      pos_q <= load_val;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/slot_map_ctrl.sv
module slot_map_ctrl
  import slot_map_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 2,
  parameter int ID_W      = 64,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [ID_W-1:0]  req_id,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_status,
  output logic [IDX_W-1:0] rsp_index,
  output logic [ID_W-1:0]  rsp_id,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [ID_W-1:0]  rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [ID_W-1:0]  wr_data,
  input  logic [CNT_W-1:0] count,
  output logic             cnt_inc,
  output logic             cnt_dec,
  input  logic [IDX_W-1:0] iter_pos,
  output logic             iter_load,
  output logic [IDX_W-1:0] iter_val,
  output logic             iter_restart
);

  localparam logic [IDX_W-1:0] FIRST_I  = IDX_W'(FIRST_IDX);
  localparam logic [IDX_W-1:0] LAST_I   = IDX_W'(NUM_SLOTS);
  localparam logic [ID_W-1:0]  ALL_ONES = '1;

  function automatic logic storable(input logic [ID_W-1:0] id);
    return (id != '0) && (id != ALL_ONES);
  endfunction

  ctrl_state_e      state_q, state_d;
  logic [2:0]       op_q, op_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] seen_q, seen_d;
  logic [7:0]       stat_q, stat_d;
  logic [IDX_W-1:0] ridx_q, ridx_d;
  logic [ID_W-1:0]  rid_q, rid_d;

  logic past_end;
  logic entry_used;

  assign past_end   = (idx_q >= LAST_I);
  assign entry_used = (rd_data != '0);
  assign rd_idx     = idx_q;

  always_comb begin
    state_d      = state_q;
    op_d         = op_q;
    id_d         = id_q;
    idx_d        = idx_q;
    seen_d       = seen_q;
    stat_d       = stat_q;
    ridx_d       = ridx_q;
    rid_d        = rid_q;
    wr_en        = 1'b0;
    wr_idx       = idx_q;
    wr_data      = '0;
    cnt_inc      = 1'b0;
    cnt_dec      = 1'b0;
    iter_load    = 1'b0;
    iter_val     = idx_q + 1'b1;
    iter_restart = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d   = req_op;
          id_d   = req_id;
          idx_d  = FIRST_I;
          seen_d = '0;
          rid_d  = req_id;
          ridx_d = '0;
          stat_d = STAT_OK;
          case (req_op)
            OP_LOOKUP: begin
              if (req_id == '0) begin
                stat_d  = STAT_NOTFOUND;
                state_d = ST_RESP;
              end else begin
                state_d = ST_MATCH;
              end
            end
            OP_WRITE, OP_CLEAR: begin
              if (!storable(req_id)) begin
                stat_d  = STAT_FAILED;
                state_d = ST_RESP;
              end else begin
                state_d = ST_MATCH;
              end
            end
            OP_FIND_FREE: state_d = ST_FREE;
            OP_NEXT, OP_REWIND: begin
              if (count == '0) begin
                rid_d        = ALL_ONES;
                iter_restart = 1'b1;
                state_d      = ST_RESP;
              end else begin
                idx_d   = (req_op == OP_REWIND) ? FIRST_I : iter_pos;
                state_d = ST_ITER;
              end
            end
            default: begin
              stat_d  = STAT_FAILED;
              state_d = ST_RESP;
            end
          endcase
        end
      end

      ST_MATCH: begin
        if (past_end || (seen_q >= count)) begin
          if (op_q == OP_WRITE) begin
            idx_d   = FIRST_I;
            state_d = ST_FREE;
          end else begin
            stat_d  = STAT_NOTFOUND;
            state_d = ST_RESP;
          end
        end else if (rd_data == id_q) begin
          ridx_d  = idx_q;
          stat_d  = STAT_OK;
          state_d = ST_RESP;
          if (op_q == OP_CLEAR) begin
            wr_en   = 1'b1;
            wr_data = '0;
            cnt_dec = 1'b1;
          end else if (op_q == OP_WRITE) begin
            wr_en   = 1'b1;
            wr_data = id_q;
          end
        end else begin
          if (entry_used) begin
            seen_d = seen_q + 1'b1;
          end
          idx_d = idx_q + 1'b1;
        end
      end

      ST_FREE: begin
        if (past_end) begin
          stat_d  = STAT_NO_SPACE;
          state_d = ST_RESP;
        end else if (!entry_used) begin
          ridx_d  = idx_q;
          stat_d  = STAT_OK;
          state_d = ST_RESP;
          if (op_q == OP_WRITE) begin
            wr_en   = 1'b1;
            wr_data = id_q;
            cnt_inc = 1'b1;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end

      ST_ITER: begin
        if (past_end) begin
          rid_d        = ALL_ONES;
          stat_d       = STAT_OK;
          iter_restart = 1'b1;
          state_d      = ST_RESP;
        end else if (entry_used) begin
          rid_d     = rd_data;
          ridx_d    = idx_q;
          stat_d    = STAT_OK;
          iter_load = 1'b1;
          state_d   = ST_RESP;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end

      ST_RESP: begin
        if (rsp_ready) begin
          state_d = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      id_q    <= '0;
      idx_q   <= FIRST_I;
      seen_q  <= '0;
      stat_q  <= STAT_OK;
      ridx_q  <= '0;
      rid_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      id_q    <= id_d;
      idx_q   <= idx_d;
      seen_q  <= seen_d;
      stat_q  <= stat_d;
      ridx_q  <= ridx_d;
      rid_q   <= rid_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_status = stat_q;
  assign rsp_index  = ridx_q;
  assign rsp_id     = rid_q;

endmodule

// File: rtl/slot_map_mgr.sv
module slot_map_mgr #(
  parameter int  NUM_SLOTS = 16,
  parameter int  FIRST_IDX = 2,
  parameter int  ID_W      = 64,
  localparam int IDX_W     = $clog2(NUM_SLOTS + 1),
  localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [ID_W-1:0]  req_id,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_status,
  output logic [IDX_W-1:0] rsp_index,
  output logic [ID_W-1:0]  rsp_id,
  output logic [CNT_W-1:0] rec_count
);

  logic [IDX_W-1:0] rd_idx;
  logic [ID_W-1:0]  rd_data;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [ID_W-1:0]  wr_data;
  logic             cnt_inc;
  logic             cnt_dec;
  logic [IDX_W-1:0] iter_pos;
  logic             iter_load;
  logic [IDX_W-1:0] iter_val;
  logic             iter_restart;

  slot_map_store #(
    .NUM_SLOTS(NUM_SLOTS), .FIRST_IDX(FIRST_IDX), .ID_W(ID_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  slot_map_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .dec(cnt_dec), .count(rec_count)
  );

  slot_map_iter #(.FIRST_IDX(FIRST_IDX), .IDX_W(IDX_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .restart(iter_restart), .load(iter_load),
    .load_val(iter_val), .pos(iter_pos)
  );

  slot_map_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .FIRST_IDX(FIRST_IDX), .ID_W(ID_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_index(rsp_index), .rsp_id(rsp_id),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .count(rec_count), .cnt_inc(cnt_inc), .cnt_dec(cnt_dec),
    .iter_pos(iter_pos), .iter_load(iter_load), .iter_val(iter_val),
    .iter_restart(iter_restart)
  );

endmodule

// File: rtl/slot_map_checker.sv
module slot_map_checker #(
  parameter int NUM_SLOTS = 16,
  parameter int FIRST_IDX = 2,
  parameter int ID_W      = 64,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_status,
  input logic [IDX_W-1:0] rsp_index,
  input logic [ID_W-1:0]  rsp_id,
  input logic [CNT_W-1:0] rec_count
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(NUM_SLOTS - FIRST_IDX);

  // R2: a pending response blocks new requests
  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2: response payload held under back-pressure
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)
                                   && $stable(rsp_index) && $stable(rsp_id)));

  // R4: a returned slot lies in the record range
  a_r4_index_window: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_index != '0) |->
      (rsp_index >= IDX_W'(FIRST_IDX) && rsp_index < IDX_W'(NUM_SLOTS)));

  // R3: a non-ok status never carries a slot
  a_r3_fail_no_index: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 8'h00) |-> (rsp_index == '0));

  // R4: count never exceeds the record capacity
  a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= CAP);

  // R8: the count moves by one, only as a response is raised
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_count != $past(rec_count)) |->
      ($rose(rsp_valid) && ((rec_count == $past(rec_count) + 1'b1) ||
                            (rec_count + 1'b1 == $past(rec_count)))));

  // R10: an ok answer without a slot is the iterator end marker
  a_r10_end_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 8'h00 && rsp_index == '0) |-> (rsp_id == '1));

endmodule

bind slot_map_mgr slot_map_checker #(
  .NUM_SLOTS(NUM_SLOTS), .FIRST_IDX(FIRST_IDX), .ID_W(ID_W),
  .IDX_W(IDX_W), .CNT_W(CNT_W)
) i_slot_map_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_index(rsp_index),
  .rsp_id(rsp_id), .rec_count(rec_count)
);

// File: tb/test_slot_map_mgr.sv
module test_slot_map_mgr;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SLOTS  = 8;
  localparam int FIRST_IDX  = 2;
  localparam int ID_W       = 64;
  localparam int IDX_W      = $clog2(NUM_SLOTS + 1);
  localparam int CNT_W      = $clog2(NUM_SLOTS + 1);
  localparam logic [63:0] ONES = '1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [2:0]       req_op = '0;
  logic [ID_W-1:0]  req_id = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b0;
  logic [7:0]       rsp_status;
  logic [IDX_W-1:0] rsp_index;
  logic [ID_W-1:0]  rsp_id;
  logic [CNT_W-1:0] rec_count;

  int n_checks = 0;
  int n_fails  = 0;

  logic [63:0] mmap [NUM_SLOTS];
  int          mcount;
  int          mpos;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_map_mgr #(.NUM_SLOTS(NUM_SLOTS), .FIRST_IDX(FIRST_IDX), .ID_W(ID_W)) i_slot_map_mgr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_id(req_id), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_index(rsp_index), .rsp_id(rsp_id),
    .rec_count(rec_count)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected result from the requirements; also advances the bench's map.
  task automatic expect_op(input logic [2:0] op, input logic [63:0] id,
                           output int e_st, output int e_idx, output logic [63:0] e_id);
    int hit;
    int fr;
    hit = 0;
    fr  = 0;
    e_st = 0; e_idx = 0; e_id = id;
    for (int i = FIRST_IDX; i < NUM_SLOTS; i++) begin
      if (hit == 0 && id != 0 && mmap[i] == id) hit = i;
      if (fr == 0 && mmap[i] == 0) fr = i;
    end
    case (op)
      3'd0: begin
        if (hit != 0) e_idx = hit; else e_st = 5;
      end
      3'd1: begin
        if (fr != 0) e_idx = fr; else e_st = 1;
      end
      3'd2: begin
        if (id == 0 || id == ONES) e_st = 3;
        else if (hit != 0) e_idx = hit;
        else if (fr != 0) begin
          e_idx = fr; mmap[fr] = id; mcount++;
        end else e_st = 1;
      end
      3'd3: begin
        if (id == 0 || id == ONES) e_st = 3;
        else if (hit != 0) begin
          e_idx = hit; mmap[hit] = 0; mcount--;
        end else e_st = 5;
      end
      3'd4, 3'd5: begin
        int got;
        got  = 0;
        e_id = ONES;
        if (op == 3'd5) mpos = FIRST_IDX;
        if (mcount != 0) begin
          for (int i = mpos; i < NUM_SLOTS; i++) begin
            if (got == 0 && mmap[i] != 0) got = i;
          end
        end
        if (got != 0) begin
          e_idx = got; e_id = mmap[got]; mpos = got + 1;
        end else mpos = FIRST_IDX;
      end
      default: e_st = 3;
    endcase
  endtask

  task automatic do_req(input logic [2:0] op, input logic [63:0] id, input int hold,
                        output logic [7:0] st, output logic [IDX_W-1:0] ix,
                        output logic [63:0] rid, output int lat);
    @(negedge clk);
    req_op = op; req_id = id; req_valid = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (lat >= 100) check("R2", "response timeout", 64'd1, 64'd0);
    st = rsp_status; ix = rsp_index; rid = rsp_id;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R2", "rsp_valid under back-pressure", 64'(rsp_valid), 64'd1);
      check("R2", "req_ready while busy", 64'(req_ready), 64'd0);
      check("R2", "status held", 64'(rsp_status), 64'(st));
      check("R2", "index held", 64'(rsp_index), 64'(ix));
      check("R2", "id held", rsp_id, rid);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [63:0] id, input string tag,
                        input int hold, output int lat);
    int e_st, e_idx;
    logic [63:0] e_id;
    logic [7:0] st;
    logic [IDX_W-1:0] ix;
    logic [63:0] rid;
    expect_op(op, id, e_st, e_idx, e_id);
    do_req(op, id, hold, st, ix, rid, lat);
    check(tag, "status", 64'(st), 64'(e_st));
    check(tag, "index", 64'(ix), 64'(e_idx));
    check(tag, "id", rid, e_id);
    check(tag, "record count", 64'(rec_count), 64'(mcount));
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R7";
      3'd1: return "R9";
      3'd2: return "R4";
      3'd3: return "R8";
      3'd4: return "R10";
      3'd5: return "R11";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL R2: watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] rng;
    for (int i = 0; i < NUM_SLOTS; i++) mmap[i] = 0;
    mcount = 0;
    mpos = FIRST_IDX;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "rec_count after reset", 64'(rec_count), 64'd0);
    check("R1", "req_ready after reset", 64'(req_ready), 64'd1);
    check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    run_op(3'd4, 64'd0, "R11", 0, lat);
    check("R12", "empty iterator latency", 64'(lat), 64'd0);
    run_op(3'd1, 64'd0, "R9", 0, lat);

    // R4 contiguous allocation, then R12 scan lengths
    run_op(3'd2, 64'h11, "R4", 0, lat);
    run_op(3'd2, 64'h22, "R4", 0, lat);
    run_op(3'd2, 64'h33, "R4", 0, lat);
    run_op(3'd0, 64'h99, "R7", 0, lat);
    check("R12", "miss latency with 3 records", 64'(lat), 64'd4);
    run_op(3'd0, 64'h33, "R7", 0, lat);
    check("R12", "hit latency slot 4", 64'(lat), 64'd3);
    run_op(3'd0, 64'd0, "R7", 0, lat);
    check("R12", "id 0 lookup latency", 64'(lat), 64'd0);

    // R5 overwrite, R2 back-pressure
    run_op(3'd2, 64'h22, "R5", 0, lat);
    run_op(3'd0, 64'h11, "R2", 3, lat);
    check("R2", "req_ready after response", 64'(req_ready), 64'd1);

    // R6 capacity and invalid ids
    run_op(3'd2, 64'h44, "R4", 0, lat);
    run_op(3'd2, 64'h55, "R4", 0, lat);
    run_op(3'd2, 64'h66, "R4", 0, lat);
    run_op(3'd2, 64'h77, "R6", 0, lat);
    run_op(3'd1, 64'd0, "R9", 0, lat);
    run_op(3'd2, 64'd0, "R6", 0, lat);
    run_op(3'd2, ONES, "R6", 0, lat);
    check("R12", "invalid write latency", 64'(lat), 64'd0);

    // R8 clear paths and reuse of the freed slot
    run_op(3'd3, 64'd0, "R8", 0, lat);
    run_op(3'd3, ONES, "R8", 0, lat);
    run_op(3'd3, 64'h99, "R8", 0, lat);
    run_op(3'd3, 64'h33, "R8", 0, lat);
    run_op(3'd0, 64'h33, "R8", 0, lat);
    run_op(3'd1, 64'd0, "R9", 0, lat);
    run_op(3'd2, 64'h77, "R8", 0, lat);

    // R10 / R11 iterator walk past the end and wrap
    run_op(3'd5, 64'd0, "R11", 0, lat);
    for (int k = 0; k < NUM_SLOTS; k++) run_op(3'd4, 64'd0, "R10", 0, lat);
    run_op(3'd3, 64'h55, "R8", 0, lat);
    run_op(3'd4, 64'd0, "R10", 0, lat);

    // R3 unknown op codes leave everything unchanged
    run_op(3'd6, 64'h11, "R3", 0, lat);
    run_op(3'd7, 64'h22, "R3", 0, lat);
    run_op(3'd0, 64'h11, "R3", 0, lat);

    // Pseudo-random mix over a pool larger than the map
    rng = 32'h1234_5678;
    for (int n = 0; n < 800; n++) begin
      logic [2:0]  op;
      logic [63:0] id;
      int r;
      int p;
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      r = int'(rng[15:0] % 16'd11);
      case (r)
        0, 1, 2: op = 3'd2;
        3, 4:    op = 3'd3;
        5:       op = 3'd0;
        6:       op = 3'd1;
        7, 8:    op = 3'd4;
        9:       op = 3'd5;
        default: op = (rng[20]) ? 3'd6 : 3'd7;
      endcase
      p = int'(rng[27:24]) % 12;
      if (p == 0) id = 64'd0;
      else if (p == 11) id = ONES;
      else id = 64'hA500_0000_0000_0000 | 64'(p);
      run_op(op, id, tag_of(op), (n % 37 == 0) ? 2 : 0, lat);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule